// File: doc/BRIEF.md
# Configurable Twofold Interpolator with Midscale Stuffing

This block is the digital upsampling path in front of a 14-bit DAC. Each accepted input sample passes through a symmetric half-band FIR filter that produces two output samples per input, which doubles the sample rate. The filter has two responses. The low-pass response keeps the baseband signal and suppresses the image that sits just above the input rate's Nyquist frequency. The high-pass response does the reverse: it keeps that upper image and rejects the baseband copy, which serves direct-IF use.

An optional stuffing stage doubles the rate a second time. After every filtered sample it emits a midscale code, which raises the level of the higher IF images. Samples are offset binary at both edges of the block. Arithmetic inside the block is two's complement, with rounding and saturation.

The block runs on one clock at the output rate. Input samples arrive with a strobe, one every 2 cycles when stuffing is off and one every 4 cycles when it is on. The two mode inputs are latched together with each input sample.

Top module: `interp2x_stuff`

## Requirements
- R1: Input and output samples are 14-bit offset binary. Midscale is code 0x2000, and a stream of midscale inputs yields midscale outputs.
- R2: Every accepted input (valid_i high at a rising edge) produces exactly 2 output samples, or 4 when stuffing is on. The first appears with valid_o high 2 rising edges after the edge that sampled valid_i. The order is the even phase first, then the centre phase.
- R3: In low-pass mode, the even-phase output is round((3*x[n] - 25*x[n-1] + 150*x[n-2] + 150*x[n-3] - 25*x[n-4] + 3*x[n-5]) / 256), and the centre-phase output is x[n-2]. Here x[n] is the newest input in two's complement.
- R4: In high-pass mode, the even-phase output is unchanged and the centre-phase output is -x[n-2]. This is the same half-band filter with each odd-indexed tap negated.
- R5: Rounding adds 128 before the arithmetic shift by 8. Results above 8191 or below -8192 clip to 0x3FFF or 0x0000 in offset binary and never wrap. This includes negating -8192 in high-pass mode.
- R6: With stuffing on, the four outputs per input are even phase, 0x2000, centre phase, 0x2000.
- R7: When inputs arrive at the rate the current mode needs, valid_o stays high on every cycle. After the last output of a sample with no newer input, valid_o falls.
- R8: hp_i and stuff_i are sampled only with valid_i. Changing them between inputs does not alter the outputs of the sample already in flight.
- R9: data_i, hp_i and stuff_i have no effect while valid_i is low. The delay line and the outputs do not change.
- R10: Asserting rst_ni low forces valid_o to 0 and data_o to 0x2000, and clears the delay line to midscale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Output-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | 14 | Input sample, offset binary |
| hp_i | input | 1 | 1 selects the high-pass (upper image) response |
| stuff_i | input | 1 | 1 enables midscale stuffing |
| valid_o | output | 1 | Output sample strobe |
| data_o | output | 14 | Output sample, offset binary |

## Verification
Two things can fall in the same cycle: the edge that loads a new input into the delay line and the edge that issues the last output of the previous sample. That last output is the centre phase, or the trailing midscale code when stuffing is on. The stimulus table sends samples back to back at exactly the mode's rate and switches the response and the stuffing setting between neighbouring entries. Every output is popped against an independent convolution over the zero-inserted stream, and any gap in valid_o while outputs are still owed is flagged. A directed case flips the mode pins in the cycle right after a load, so the in-flight sequence must still follow the latched mode.

// File: rtl/interp_pkg.sv
package interp_pkg;
  localparam int unsigned COEF_W     = 10;
  localparam int unsigned COEF_SHIFT = 8;   // coefficients scaled by 256
  localparam int unsigned SIDE_TAPS  = 3;   // nonzero taps each side of centre
  localparam int unsigned HIST_LEN   = 2 * SIDE_TAPS;
  localparam int unsigned CENTRE_IDX = SIDE_TAPS - 1;
  localparam int unsigned MAX_SLOTS  = 4;
  localparam int unsigned SLOT_W     = $clog2(MAX_SLOTS);
  localparam int unsigned OUT_LATENCY = 2;  // edges from strobe to first output

  typedef enum logic [1:0] {SRC_EVEN = 2'd0, SRC_ODD = 2'd1, SRC_MID = 2'd2} src_e;

  // k = 0 is the outermost tap
  function automatic logic signed [COEF_W-1:0] side_coef(input int unsigned k);
    case (k)
      0:       return COEF_W'(3);
      1:       return COEF_W'(-25);
      default: return COEF_W'(150);
    endcase
  endfunction
endpackage

// File: rtl/interp_hist.sv
module interp_hist import interp_pkg::*; #(
  parameter int unsigned W     = 14,
  parameter int unsigned DEPTH = HIST_LEN
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic signed [W-1:0] din_i,
  output logic signed [W-1:0] hist_o [DEPTH]
);
  logic signed [W-1:0] hist_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) hist_q[i] <= '0;
    end else if (load_i) begin
      hist_q[0] <= din_i;
      for (int i = 1; i < int'(DEPTH); i++) hist_q[i] <= hist_q[i-1];
    end
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/interp_phase_calc.sv
module interp_phase_calc import interp_pkg::*; #(
  parameter int unsigned W = 14
) (
  input  logic signed [W-1:0] hist_i [HIST_LEN],
  input  logic                hp_i,
  output logic signed [W-1:0] even_o,
  output logic signed [W-1:0] odd_o
);
  localparam int unsigned ACC_W = W + COEF_W + $clog2(HIST_LEN) + 1;
  localparam logic signed [W-1:0]     S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]     S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] RND   = ACC_W'(1) <<< (COEF_SHIFT - 1);

  logic signed [ACC_W-1:0] prod [HIST_LEN];
  logic signed [ACC_W-1:0] acc, scaled;

  for (genvar i = 0; i < int'(HIST_LEN); i++) begin : g_tap
    localparam int unsigned K = (i < int'(SIDE_TAPS)) ? i : HIST_LEN - 1 - i;
    assign prod[i] = ACC_W'(hist_i[i]) * ACC_W'(side_coef(K));
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < int'(HIST_LEN); i++) acc = acc + prod[i];
    scaled = (acc + RND) >>> COEF_SHIFT;
    if (scaled > ACC_W'(S_MAX))      even_o = S_MAX;
    else if (scaled < ACC_W'(S_MIN)) even_o = S_MIN;
    else                             even_o = scaled[W-1:0];
  end

  // high-pass: centre tap sits at an odd index, so only this phase flips
  always_comb begin
    if (!hp_i)                           odd_o = hist_i[CENTRE_IDX];
    else if (hist_i[CENTRE_IDX] == S_MIN) odd_o = S_MAX;
    else                                 odd_o = -hist_i[CENTRE_IDX];
  end
endmodule

// File: rtl/interp_seq.sv
module interp_seq import interp_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic hp_i,
  input  logic stuff_i,
  output logic active_o,
  output logic hp_o,
  output src_e src_o
);
  logic [SLOT_W-1:0] slot_q;
  logic              active_q, hp_q, stuff_q, last;

  assign last = stuff_q ? (slot_q == SLOT_W'(MAX_SLOTS - 1)) : (slot_q == SLOT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= '0;
      active_q <= 1'b0;
      hp_q     <= 1'b0;
      stuff_q  <= 1'b0;
    end else if (valid_i) begin
      slot_q   <= '0;
      active_q <= 1'b1;
      hp_q     <= hp_i;
      stuff_q  <= stuff_i;
    end else if (active_q) begin
      if (last) active_q <= 1'b0;
      else      slot_q   <= slot_q + SLOT_W'(1);
    end
  end

  always_comb begin
    if (!stuff_q)      src_o = slot_q[0] ? SRC_ODD : SRC_EVEN;
    else if (slot_q[0]) src_o = SRC_MID;
    else               src_o = slot_q[1] ? SRC_ODD : SRC_EVEN;
  end

  assign active_o = active_q;
  assign hp_o     = hp_q;
endmodule

// File: rtl/interp2x_stuff.sv
module interp2x_stuff import interp_pkg::*; #(
  parameter int unsigned SAMPLE_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic                hp_i,
  input  logic                stuff_i,
  output logic                valid_o,
  output logic [SAMPLE_W-1:0] data_o
);
  localparam logic [SAMPLE_W-1:0] MID_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [SAMPLE_W-1:0] din_s, even_s, odd_s, sel_s;
  logic signed [SAMPLE_W-1:0] hist [HIST_LEN];
  logic                       active, hp_lat;
  src_e                       src;
  logic                       valid_q;
  logic [SAMPLE_W-1:0]        data_q;

  assign din_s = {~data_i[SAMPLE_W-1], data_i[SAMPLE_W-2:0]};

  interp_hist #(.W(SAMPLE_W), .DEPTH(HIST_LEN)) i_hist (
    .clk_i, .rst_ni, .load_i(valid_i), .din_i(din_s), .hist_o(hist)
  );

  interp_seq i_seq (
    .clk_i, .rst_ni, .valid_i, .hp_i, .stuff_i,
    .active_o(active), .hp_o(hp_lat), .src_o(src)
  );

  interp_phase_calc #(.W(SAMPLE_W)) i_calc (
    .hist_i(hist), .hp_i(hp_lat), .even_o(even_s), .odd_o(odd_s)
  );

  always_comb begin
    case (src)
      SRC_EVEN: sel_s = even_s;
      SRC_ODD:  sel_s = odd_s;
      default:  sel_s = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= MID_CODE;
    end else begin
      valid_q <= active;
      if (active) data_q <= {~sel_s[SAMPLE_W-1], sel_s[SAMPLE_W-2:0]};
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/interp2x_stuff_chk.sv
module interp2x_stuff_chk #(
  parameter int unsigned SAMPLE_W = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                stuff_i,
  input logic                valid_o,
  input logic [SAMPLE_W-1:0] data_o
);
  localparam logic [SAMPLE_W-1:0] MID_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [2:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_rst_q <= '0;
    else if (since_rst_q != 3'd7) since_rst_q <= since_rst_q + 3'd1;
  end

  assert_out_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q >= 3'd2 && $past(valid_i, 2)) |-> valid_o);

  assert_stuff_mid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q >= 3'd3 && $past(valid_i, 3) && $past(stuff_i, 3) && !$past(valid_i, 2))
    |-> (data_o == MID_CODE));

  assert_valid_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q >= 3'd4 && $past(valid_i, 4) && !$past(stuff_i, 4)
     && !$past(valid_i, 3) && !$past(valid_i, 2)) |-> !valid_o);

  // checks the reset state itself, so it is not disabled by reset
  assert_reset_state_R10: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && data_o == MID_CODE));
endmodule

bind interp2x_stuff interp2x_stuff_chk #(.SAMPLE_W(SAMPLE_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .stuff_i(stuff_i),
  .valid_o(valid_o), .data_o(data_o)
);

// File: tb/test_interp2x_stuff.sv
module test_interp2x_stuff;
  localparam int NV = 20;
  // {hp, stuff, data[13:0]}
  localparam logic [15:0] VEC [NV] = '{
    16'h2000, 16'h2800, 16'h3000, 16'h1000, 16'h2400, 16'h1C00,
    16'hB000, 16'h8000, 16'hBFFF, 16'hBFFF, 16'h0000, 16'h2000,
    16'h7FFF, 16'h4000, 16'hC000, 16'hFFFF, 16'h6100, 16'h6200,
    16'h1F00, 16'h2000
  };
  localparam int HB [11] = '{3, 0, -25, 0, 150, 256, 150, 0, -25, 0, 3};

  logic clk = 1'b0, rst_n = 1'b1;
  logic valid_i = 1'b0, hp_i = 1'b0, stuff_i = 1'b0;
  logic [13:0] data_i = 14'h2000;
  logic valid_o;
  logic [13:0] data_o;

  int n_chk = 0, n_fail = 0, run_len = 0;
  int ubuf [11];
  int exp_q [$];
  string tag_q [$];
  time drive_t, first_t;
  bit done = 0;

  always #5 clk = ~clk;

  interp2x_stuff i_interp2x_stuff (
    .clk_i(clk), .rst_ni(rst_n), .valid_i, .data_i, .hp_i, .stuff_i, .valid_o, .data_o
  );

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int j = 0; j < 11; j++) ubuf[j] = 0;
  endfunction

  function automatic void model_push(input int x);
    for (int j = 10; j > 0; j--) ubuf[j] = ubuf[j-1];
    ubuf[0] = x;
  endfunction

  function automatic int model_out(input bit hp, output bit clip);
    int s = 0;
    for (int j = 0; j < 11; j++) s += ((hp && (j % 2 == 1)) ? -HB[j] : HB[j]) * ubuf[j];
    s = (s + 128) >>> 8;
    clip = 0;
    if (s > 8191) begin s = 8191; clip = 1; end
    else if (s < -8192) begin s = -8192; clip = 1; end
    return s + 8192;
  endfunction

  task automatic send(input logic [13:0] d, input bit hp, input bit st,
                      input bit hp_nx, input bit st_nx, input string tg);
    bit c0, c1;
    int e, o;
    model_push(int'(d) - 8192);
    e = model_out(hp, c0);
    model_push(0);
    o = model_out(hp, c1);
    exp_q.push_back(e); tag_q.push_back(tg != "" ? tg : (c0 ? "R5" : "R3"));
    if (st) begin exp_q.push_back(8192); tag_q.push_back("R6"); end
    exp_q.push_back(o); tag_q.push_back(tg != "" ? tg : (c1 ? "R5" : (hp ? "R4" : "R3")));
    if (st) begin exp_q.push_back(8192); tag_q.push_back("R6"); end
    valid_i = 1'b1; data_i = d; hp_i = hp; stuff_i = st;
    drive_t = $time;
    @(negedge clk);
    valid_i = 1'b0; data_i = ~d; hp_i = hp_nx; stuff_i = st_nx; // R9 junk while idle
    repeat ((st ? 4 : 2) - 1) @(negedge clk);
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
    chk("R2 outputs owed", exp_q.size(), 0);
    chk("R7 valid falls when idle", int'(valid_o), 0);
  endtask

  always @(negedge clk) begin
    if (valid_o) begin
      if (run_len == 0) first_t = $time;
      if (exp_q.size() == 0) chk("R2 unexpected output", 1, 0);
      else chk(tag_q.pop_front(), int'(data_o), exp_q.pop_front());
      run_len++;
    end else begin
      if (run_len > 0 && exp_q.size() > 0) chk("R7 gap in valid", 0, 1);
      run_len = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [13:0] held;
    model_clear();
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", int'(valid_o), 0);
    chk("R10 reset data", int'(data_o), 14'h2000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 midscale in, then table walk through R3..R7
    for (int i = 0; i < NV; i++)
      send(VEC[i][13:0], VEC[i][15], VEC[i][14], VEC[i][15], VEC[i][14], (i == 0) ? "R1" : "");
    drain();

    // R2 latency from idle
    send(14'h2A00, 1'b0, 1'b0, 1'b0, 1'b0, "");
    drain();
    chk("R2 latency ns", int'(first_t - drive_t), 20);

    // R9 inputs ignored without strobe
    held = data_o;
    data_i = 14'h0123; hp_i = 1'b1; stuff_i = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 no valid", int'(valid_o), 0);
    chk("R9 data held", int'(data_o), int'(held));
    send(14'h2000, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    drain();

    // R8 modes flip right after the strobe
    send(14'h3000, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
    send(14'h0800, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
    drain();

    // R10 reset clears history
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    exp_q.delete(); tag_q.delete();
    repeat (2) @(negedge clk);
    chk("R10 reset valid", int'(valid_o), 0);
    chk("R10 reset data", int'(data_o), 14'h2000);
    rst_n = 1'b1;
    @(negedge clk);
    send(14'h3FFF, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule